// File: doc/BRIEF.md
# NAND Page Column Pointer Controller

This block keeps the column pointer and the page pointer that a NAND page register uses while bytes are read out serially. A page holds a main area and a short spare area behind it, 512 plus 16 bytes by default. A read opcode picks the region where the next address load starts: the lower half of the main area, the upper half, or the spare area. Each qualified read strobe then moves the column forward by one. At the last column of a page the pointer steps to the next page and raises a one-cycle transfer request, so that the array can refill the page register. At the last page of an erase block the walk halts until a new address arrives.

The spare region is sticky. It stays selected through later address loads and through the reset opcode, and only the lower-half opcode clears it. The upper-half opcode applies to a single address load only. A configuration pin shortens the page to the main area alone, and in that mode the spare opcode is refused. The controller holds no data and has no streaming path. Opcodes, address loads and read strobes are single-cycle pulses with no back-pressure. The busy input is the only way to stall the pointer.

Top module: `nand_colptr`

## Requirements
- R1: After reset col_ptr and page_ptr are 0, xfer_req and seq_end are 0, the lower-half region is selected and no read mode is armed.
- R2: After opcode 0x00, an address load sets col_ptr to addr_col (0..255) and page_ptr to addr_page.
- R3: Opcode 0x01 makes only the next address load start at 256 + addr_col. Later loads start in the lower half again. When a page started this way wraps, the next page begins at column 0.
- R4: Opcode 0x50 makes address loads start at 512 + addr_col[3:0], and addr_col[7:4] is ignored. The region then stays in force across further loads, opcode 0x01 and opcode 0xFF until opcode 0x00 is given.
- R5: When a read opcode has armed the block, each rd_strobe pulse adds 1 to col_ptr, with or without a preceding address load. Before arming, or after 0xFF, rd_strobe has no effect.
- R6: While busy is 1, rd_strobe leaves col_ptr and page_ptr unchanged.
- R7: A strobe at the last column (527 with page512 = 0) of a page that is not last in its block moves page_ptr up by 1 and sets col_ptr to 0. xfer_req is then 1 for exactly the one following cycle.
- R8: In the spare region a page wrap sets col_ptr to 512 instead of 0.
- R9: With page512 = 1 the last column is 511, and opcode 0x50 is ignored (no region change, no arming).
- R10: A strobe at the last column of the last page in a block (page_ptr low log2(PAGES_PER_BLK) bits all ones) sets seq_end to 1 and gives no xfer_req. Pointers then hold against strobes until the next address load, which clears seq_end.
- R11: An address load while armed gives xfer_req = 1 in the following cycle. An address load while not armed gives none.
- R12: Opcode 0xFF clears col_ptr, page_ptr and seq_end to 0 and disarms reading. The selected region is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page512 | input | 1 | 1 selects a main-area-only page length |
| cmd_valid | input | 1 | Opcode pulse, has priority over the other inputs |
| cmd_code | input | 8 | Opcode byte |
| addr_valid | input | 1 | Address load pulse |
| addr_col | input | 8 | Column offset within the selected region |
| addr_page | input | 15 | Page address (block and page within block) |
| rd_strobe | input | 1 | One pulse per read-enable falling edge |
| busy | input | 1 | Array busy, stalls pointer movement |
| col_ptr | output | 10 | Current column |
| page_ptr | output | 15 | Current page |
| xfer_req | output | 1 | One-cycle array-to-register transfer request |
| seq_end | output | 1 | Sequential read halted at a block boundary |

## Verification
The assertions assume that page512 stays fixed while a spare-region walk is in progress. They also assume that an opcode and an address load never arrive in the same cycle. The hold checks look only at cycles that carry neither of these inputs. The stimulus changes page512 only after the lower-half opcode has cleared the spare region, and it applies each input pulse alone for one cycle. The sweeps cover every addr_col value in each region, complete block walks in both page lengths and the wraps at every region boundary, on a geometry of four pages per block.

// File: rtl/ncp_pkg.sv
package ncp_pkg;
  typedef enum logic [1:0] {
    RGN_LOW   = 2'd0,
    RGN_HIGH  = 2'd1,
    RGN_SPARE = 2'd2
  } ncp_region_e;

  localparam logic [7:0] OPC_READ_LOW   = 8'h00;
  localparam logic [7:0] OPC_READ_HIGH  = 8'h01;
  localparam logic [7:0] OPC_READ_SPARE = 8'h50;
  localparam logic [7:0] OPC_RESET      = 8'hFF;
endpackage

// File: rtl/ncp_region_reg.sv
module ncp_region_reg
  import ncp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        page512,
  input  logic        cmd_valid,
  input  logic [7:0]  cmd_code,
  input  logic        addr_load,
  output ncp_region_e region,
  output logic        armed
);
  // Region select: spare is sticky, upper half is one-shot.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      region <= RGN_LOW;
      armed  <= 1'b0;
    end else if (cmd_valid) begin
      case (cmd_code)
        OPC_RESET: armed <= 1'b0;
        OPC_READ_LOW: begin
          region <= RGN_LOW;
          armed  <= 1'b1;
        end
        OPC_READ_HIGH: begin
          armed <= 1'b1;
          if (region != RGN_SPARE) region <= RGN_HIGH;
        end
        OPC_READ_SPARE: begin
          if (!page512) begin
            region <= RGN_SPARE;
            armed  <= 1'b1;
          end
        end
        default: ;
      endcase
    end else if (addr_load && region == RGN_HIGH) begin
      region <= RGN_LOW;
    end
  end

  // R4: spare region only leaves on the lower-half opcode
  assert_spare_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RGN_SPARE && !(cmd_valid && cmd_code == OPC_READ_LOW))
      |=> region == RGN_SPARE);
endmodule

// File: rtl/ncp_col_ctr.sv
module ncp_col_ctr
  import ncp_pkg::*;
#(
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int COL_W       = 10,
  parameter int ACOL_W      = 8,
  parameter int SP_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page512,
  input  ncp_region_e       region,
  input  logic              addr_load,
  input  logic [ACOL_W-1:0] addr_col,
  input  logic              clear,
  input  logic              step,
  input  logic              blk_last,
  output logic [COL_W-1:0]  col,
  output logic              at_last
);
  localparam logic [COL_W-1:0] LAST_FULL  = COL_W'(MAIN_BYTES + SPARE_BYTES - 1);
  localparam logic [COL_W-1:0] LAST_MAIN  = COL_W'(MAIN_BYTES - 1);
  localparam logic [COL_W-1:0] HALF_BASE  = COL_W'(MAIN_BYTES / 2);
  localparam logic [COL_W-1:0] SPARE_BASE = COL_W'(MAIN_BYTES);

  logic [COL_W-1:0] start_col;
  logic [COL_W-1:0] wrap_col;

  always_comb begin
    case (region)
      RGN_HIGH:  start_col = HALF_BASE + COL_W'(addr_col);
      RGN_SPARE: start_col = SPARE_BASE + COL_W'(addr_col[SP_W-1:0]);
      default:   start_col = COL_W'(addr_col);
    endcase
  end

  assign wrap_col = (region == RGN_SPARE) ? SPARE_BASE : '0;
  assign at_last  = (col == (page512 ? LAST_MAIN : LAST_FULL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0;
    end else if (clear) begin
      col <= '0;
    end else if (addr_load) begin
      col <= start_col;
    end else if (step) begin
      if (!at_last)      col <= col + 1'b1;
      else if (!blk_last) col <= wrap_col;
    end
  end

  // R4: a spare-region load lands inside the spare window
  assert_spare_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_load && !clear && region == RGN_SPARE)
      |=> (col >= SPARE_BASE && col <= LAST_FULL));
  // R8: spare wrap returns to the spare base
  assert_spare_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_last && !blk_last && !clear && !addr_load && region == RGN_SPARE)
      |=> col == SPARE_BASE);
endmodule

// File: rtl/ncp_page_ctr.sv
module ncp_page_ctr #(
  parameter int PG_W   = 5,
  parameter int PAGE_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              addr_load,
  input  logic [PAGE_W-1:0] addr_page,
  input  logic              armed,
  input  logic              wrap_step,
  output logic [PAGE_W-1:0] page,
  output logic              blk_last,
  output logic              seq_end,
  output logic              xfer_req
);
  assign blk_last = &page[PG_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page     <= '0;
      seq_end  <= 1'b0;
      xfer_req <= 1'b0;
    end else if (clear) begin
      page     <= '0;
      seq_end  <= 1'b0;
      xfer_req <= 1'b0;
    end else begin
      xfer_req <= (addr_load && armed) || (wrap_step && !blk_last);
      if (addr_load) begin
        page    <= addr_page;
        seq_end <= 1'b0;
      end else if (wrap_step) begin
        if (blk_last) seq_end <= 1'b1;
        else          page    <= page + 1'b1;
      end
    end
  end

  // R10: leaving the last page of a block halts instead of stepping
  assert_block_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_step && blk_last && !clear && !addr_load)
      |=> (seq_end && $stable(page) && !xfer_req));
endmodule

// File: rtl/nand_colptr.sv
module nand_colptr
  import ncp_pkg::*;
#(
  parameter int MAIN_BYTES    = 512,
  parameter int SPARE_BYTES   = 16,
  parameter int PAGES_PER_BLK = 32,
  parameter int BLK_W         = 10,
  localparam int COL_W  = $clog2(MAIN_BYTES + SPARE_BYTES),
  localparam int ACOL_W = $clog2(MAIN_BYTES / 2),
  localparam int SP_W   = $clog2(SPARE_BYTES),
  localparam int PG_W   = $clog2(PAGES_PER_BLK),
  localparam int PAGE_W = BLK_W + PG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page512,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic              addr_valid,
  input  logic [ACOL_W-1:0] addr_col,
  input  logic [PAGE_W-1:0] addr_page,
  input  logic              rd_strobe,
  input  logic              busy,
  output logic [COL_W-1:0]  col_ptr,
  output logic [PAGE_W-1:0] page_ptr,
  output logic              xfer_req,
  output logic              seq_end
);
  localparam logic [COL_W-1:0] COL_MAX = COL_W'(MAIN_BYTES + SPARE_BYTES - 1);

  ncp_region_e region;
  logic armed, addr_load, clear, step, at_last, blk_last, wrap_step;

  // Opcodes win over address loads, both win over strobes.
  assign clear     = cmd_valid && (cmd_code == OPC_RESET);
  assign addr_load = addr_valid && !cmd_valid;
  assign step      = rd_strobe && armed && !busy && !seq_end && !cmd_valid && !addr_valid;
  assign wrap_step = step && at_last;

  ncp_region_reg u_region (
    .clk       (clk),
    .rst_n     (rst_n),
    .page512   (page512),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .addr_load (addr_load),
    .region    (region),
    .armed     (armed)
  );

  ncp_col_ctr #(
    .MAIN_BYTES  (MAIN_BYTES),
    .SPARE_BYTES (SPARE_BYTES),
    .COL_W       (COL_W),
    .ACOL_W      (ACOL_W),
    .SP_W        (SP_W)
  ) u_col (
    .clk       (clk),
    .rst_n     (rst_n),
    .page512   (page512),
    .region    (region),
    .addr_load (addr_load),
    .addr_col  (addr_col),
    .clear     (clear),
    .step      (step),
    .blk_last  (blk_last),
    .col       (col_ptr),
    .at_last   (at_last)
  );

  ncp_page_ctr #(
    .PG_W   (PG_W),
    .PAGE_W (PAGE_W)
  ) u_page (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .addr_load (addr_load),
    .addr_page (addr_page),
    .armed     (armed),
    .wrap_step (wrap_step),
    .page      (page_ptr),
    .blk_last  (blk_last),
    .seq_end   (seq_end),
    .xfer_req  (xfer_req)
  );

  // R6: busy freezes both pointers
  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmd_valid && !addr_valid) |=> ($stable(col_ptr) && $stable(page_ptr)));
  // R10: a halted walk ignores strobes
  assert_halt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_end && !cmd_valid && !addr_valid)
      |=> ($stable(col_ptr) && $stable(page_ptr) && !xfer_req));
  // R11: a transfer request always follows a load or a strobe
  assert_xfer_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> $past(addr_valid || rd_strobe));
  // R7: column never leaves the page
  assert_col_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    col_ptr <= COL_MAX);
endmodule

// File: tb/test_nand_colptr.sv
module test_nand_colptr;
  localparam int PPB    = 4;
  localparam int BLKW   = 3;
  localparam int PAGE_W = BLKW + $clog2(PPB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic page512 = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_code = '0;
  logic addr_valid = 1'b0;
  logic [7:0] addr_col = '0;
  logic [PAGE_W-1:0] addr_page = '0;
  logic rd_strobe = 1'b0;
  logic busy = 1'b0;
  logic [9:0] col_ptr;
  logic [PAGE_W-1:0] page_ptr;
  logic xfer_req, seq_end;

  int checks = 0;
  int errors = 0;
  logic got_xfer = 1'b0;

  int m_col = 0, m_page = 0, m_rgn = 0;
  bit m_armed = 0, m_stop = 0, m_xfer = 0, m_p512 = 0;

  always #5ns clk = ~clk;

  nand_colptr #(.PAGES_PER_BLK(PPB), .BLK_W(BLKW)) i_nand_colptr (
    .clk(clk), .rst_n(rst_n), .page512(page512),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .addr_valid(addr_valid), .addr_col(addr_col), .addr_page(addr_page),
    .rd_strobe(rd_strobe), .busy(busy),
    .col_ptr(col_ptr), .page_ptr(page_ptr), .xfer_req(xfer_req), .seq_end(seq_end)
  );

  task automatic check_state(input string tag);
    checks++;
    if (col_ptr !== 10'(m_col) || page_ptr !== PAGE_W'(m_page) ||
        got_xfer !== m_xfer || seq_end !== m_stop) begin
      errors++;
      $display("FAIL %s: col=%0d page=%0d xfer=%0b end=%0b, expected col=%0d page=%0d xfer=%0b end=%0b",
               tag, col_ptr, page_ptr, got_xfer, seq_end, m_col, m_page, m_xfer, m_stop);
    end
  endtask

  task automatic do_cmd(input logic [7:0] c, input string tag);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk); cmd_valid = 1'b0; got_xfer = xfer_req;
    m_xfer = 0;
    if (c == 8'hFF) begin m_col = 0; m_page = 0; m_stop = 0; m_armed = 0; end
    else if (c == 8'h00) begin m_rgn = 0; m_armed = 1; end
    else if (c == 8'h01) begin m_armed = 1; if (m_rgn != 2) m_rgn = 1; end
    else if (c == 8'h50 && !m_p512) begin m_rgn = 2; m_armed = 1; end
    check_state(tag);
  endtask

  task automatic do_addr(input int c, input int p, input string tag);
    @(negedge clk); addr_valid = 1'b1; addr_col = 8'(c); addr_page = PAGE_W'(p);
    @(negedge clk); addr_valid = 1'b0; got_xfer = xfer_req;
    m_col  = (m_rgn == 0) ? c : (m_rgn == 1) ? 256 + c : 512 + (c % 16);
    m_page = p; m_stop = 0; m_xfer = m_armed;
    if (m_rgn == 1) m_rgn = 0;
    check_state(tag);
  endtask

  task automatic do_strobe(input string tag);
    int last;
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0; got_xfer = xfer_req;
    m_xfer = 0;
    last = m_p512 ? 511 : 527;
    if (m_armed && !busy && !m_stop) begin
      if (m_col == last) begin
        if (m_page % PPB == PPB - 1) m_stop = 1;
        else begin m_page++; m_col = (m_rgn == 2) ? 512 : 0; m_xfer = 1; end
      end else m_col++;
    end
    check_state(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 reset state");
    repeat (3) do_strobe("R5 unarmed strobe");

    do_cmd(8'h00, "R2");
    for (int c = 0; c < 256; c++) do_addr(c, 5, "R2 R11 low start");

    for (int c = 0; c < 256; c++) begin
      do_cmd(8'h01, "R3");
      do_addr(c, 3, "R3 high start");
    end
    do_addr(10, 3, "R3 one-shot");

    do_cmd(8'h50, "R4");
    for (int c = 0; c < 256; c++) do_addr(c, 2, "R4 spare start");
    do_cmd(8'h01, "R4 high ignored in spare");
    do_addr(3, 2, "R4 sticky");
    do_cmd(8'hFF, "R12 clear");
    do_strobe("R12 disarmed strobe");
    do_addr(7, 1, "R12 R4 load unarmed");
    do_strobe("R12 disarmed strobe");
    do_cmd(8'h00, "R4 leave spare");
    do_strobe("R5 strobe without address");
    do_addr(3, 1, "R4 low again");

    do_addr(7, 0, "R6 setup");
    busy = 1'b1;
    repeat (3) do_strobe("R6 busy hold");
    busy = 1'b0;
    do_strobe("R6 release");

    do_addr(0, 8, "R7 seq setup");
    repeat (4 * 528 + 5) do_strobe("R7 R10 block walk");
    do_addr(0, 9, "R10 load clears");

    do_cmd(8'h01, "R3");
    do_addr(250, 1, "R3 wrap setup");
    repeat (25) do_strobe("R3 wrap to zero");

    do_cmd(8'h50, "R8");
    do_addr(14, 0, "R8 spare setup");
    repeat (20) do_strobe("R8 spare wrap");

    do_cmd(8'h00, "R9");
    page512 = 1'b1; m_p512 = 1;
    do_cmd(8'h50, "R9 spare refused");
    do_addr(4, 0, "R9 load after refused");
    do_cmd(8'h01, "R9");
    do_addr(255, 0, "R9 at 511");
    repeat (3) do_strobe("R9 wrap at 511");
    do_addr(0, 4, "R9 walk setup");
    repeat (4 * 512 + 2) do_strobe("R9 R10 short walk");
    do_cmd(8'hFF, "R12 clear from halt");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule